// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the two low-power states of a small microcontroller core. Software requests a state by writing a pair of mode bits. In the light-sleep state the CPU clock stops while the peripheral clock keeps running. In the deep-sleep state the oscillator is modelled as stopped, so both clock enables drop. The block also filters the raw reset pin into an internal reset. While a low-power state is active it drives override controls for the address-latch strobe, the program-fetch strobe and the two external-bus ports.

A free-running machine-cycle timer divides the oscillator by `MC_LEN` clocks. The timer sets when the CPU is allowed to wake after an interrupt, and it sets how long the reset pin must stay high before the internal reset fires. The timer stops in deep sleep. A high reset pin restarts it.

Top module: `lpm_ctrl`

## Requirements
- R1: After `rst_n` is released, the block is in the running state: `cpu_clk_en`=1, `per_clk_en`=1, `sys_rst`=0, `idle_flag`=0, `pd_flag`=0, `pin_hold`=0.
- R2: In the running state with `sys_rst`=0, a cycle with `mode_wr`=1, `idle_req`=1 and `pd_req`=0 sets `idle_flag` and clears `cpu_clk_en` on the next cycle, while `per_clk_en` stays 1. Mode writes are ignored while `sys_rst` is high.
- R3: A mode write with `pd_req`=1 selects deep sleep whatever `idle_req` holds. On the next cycle `pd_flag`=1 and both clock enables are 0.
- R4: In light sleep, any `irq` line seen high is remembered. At the next machine-cycle boundary (the last clock of an `MC_LEN`-clock machine cycle) `idle_flag` clears, and `cpu_clk_en` is 1 from the following cycle. An interrupt present on the boundary clock itself wakes the CPU at that same boundary.
- R5: Deep sleep ignores `irq` and mode writes. Only `sys_rst` ends it.
- R6: `rst_pin` passes through a two-flop synchroniser. `sys_rst` goes high on the cycle after the `RST_MC`-th machine-cycle boundary counted while the synchronised pin is high. A low synchronised pin clears the count, and `sys_rst` drops on the cycle after it. Boundaries are counted only while the oscillator runs. In deep sleep, a high synchronised pin restarts it.
- R7: While `sys_rst` is high, the next cycle is in the running state, with both flags 0 and both clock enables 1.
- R8: If the synchronised reset pin goes high during light sleep, the CPU resumes at once: `cpu_clk_en`=1 and `ram_wr_block`=1, with `idle_flag` still 1. This lasts until `sys_rst` fires. If the pin falls first, the block returns to running with `ram_wr_block`=0.
- R9: In light sleep `pin_hold`=1 and `pin_level`=1 (strobes held high). In deep sleep `pin_hold`=1 and `pin_level`=0. In every other state both are 0.
- R10: With `ext_code`=1, `p0_float`=1 in both sleep states, and `p2_addr_hold`=1 in light sleep only (in deep sleep port 2 drives its data latch). With `ext_code`=0, or outside the sleep states, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | Raw active-high reset pin |
| mode_wr | input | 1 | Strobe: write the mode bits |
| idle_req | input | 1 | Mode bit requesting light sleep |
| pd_req | input | 1 | Mode bit requesting deep sleep |
| irq | input | NIRQ | Enabled interrupt request lines |
| ext_code | input | 1 | Code executes from external program memory |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral and oscillator clock enable |
| sys_rst | output | 1 | Filtered internal reset |
| ram_wr_block | output | 1 | Blocks internal RAM writes |
| idle_flag | output | 1 | Light-sleep mode bit as seen by software |
| pd_flag | output | 1 | Deep-sleep mode bit as seen by software |
| pin_hold | output | 1 | Override the two bus strobes |
| pin_level | output | 1 | Level forced on the strobes while overridden |
| p0_float | output | 1 | Port 0 released to high impedance |
| p2_addr_hold | output | 1 | Port 2 keeps the high address byte (else its latch) |

## Verification
A wrong state register shows at once in the cycle after the edge: the clock enables, the flags and the pin overrides are all decoded from it. A machine-cycle timer that drifts shows only at a wake-up or reset boundary, up to `MC_LEN` cycles later. A reset-filter count that is off moves the edge of `sys_rst` by a whole machine cycle. A lost wake request keeps `cpu_clk_en` low past the boundary where it should have risen. The bench model therefore compares every output on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    LP_RUN      = 2'd0,
    LP_IDLE     = 2'd1,
    LP_DOWN     = 2'd2,
    LP_IDLE_RST = 2'd3
  } lp_state_t;
endpackage

// File: rtl/lpm_cycle_timer.sv
module lpm_cycle_timer #(
  parameter int MC_LEN = 12
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (MC_LEN > 1) ? $clog2(MC_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(MC_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) begin
      if (cnt_q == LAST) cnt_d = '0;
      else               cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpm_reset_filter.sv
module lpm_reset_filter #(
  parameter int RST_MC = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic tick_i,
  output logic pin_sync_o,
  output logic rst_o
);
  localparam int HW = $clog2(RST_MC + 1);
  localparam logic [HW-1:0] HI_MAX = HW'(RST_MC);

  logic [1:0]    sync_q;
  logic [HW-1:0] hi_q, hi_d;

  assign pin_sync_o = sync_q[1];
  assign rst_o      = (hi_q == HI_MAX);

  always_comb begin
    hi_d = hi_q;
    if (!sync_q[1])                  hi_d = '0;
    else if (tick_i && hi_q != HI_MAX) hi_d = hi_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hi_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      hi_q   <= hi_d;
    end
  end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int NIRQ = 5
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            sys_rst_i,
  input  logic            pin_s_i,
  input  logic            tick_i,
  input  logic            mode_wr_i,
  input  logic            idle_req_i,
  input  logic            pd_req_i,
  input  logic [NIRQ-1:0] irq_i,
  output lp_state_t       state_o
);
  lp_state_t state_q, state_d;
  logic      wake_q, wake_d;
  logic      any_irq;

  assign any_irq = |irq_i;
  assign state_o = state_q;

  always_comb begin
    state_d = state_q;
    wake_d  = wake_q;
    if (sys_rst_i) begin
      state_d = LP_RUN;
      wake_d  = 1'b0;
    end else begin
      unique case (state_q)
        LP_RUN: begin
          if (mode_wr_i && pd_req_i)        state_d = LP_DOWN;
          else if (mode_wr_i && idle_req_i) state_d = LP_IDLE;
        end
        LP_IDLE: begin
          if (pin_s_i) begin
            state_d = LP_IDLE_RST;
            wake_d  = 1'b0;
          end else if (tick_i && (wake_q || any_irq)) begin
            state_d = LP_RUN;
            wake_d  = 1'b0;
          end else begin
            wake_d  = wake_q || any_irq;
          end
        end
        LP_IDLE_RST: begin
          if (!pin_s_i) state_d = LP_RUN;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LP_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end
endmodule

// File: rtl/lpm_pin_ctl.sv
module lpm_pin_ctl
  import lpm_pkg::*;
(
  input  lp_state_t state_i,
  input  logic      ext_code_i,
  output logic      cpu_clk_en_o,
  output logic      per_clk_en_o,
  output logic      ram_wr_block_o,
  output logic      idle_flag_o,
  output logic      pd_flag_o,
  output logic      pin_hold_o,
  output logic      pin_level_o,
  output logic      p0_float_o,
  output logic      p2_addr_hold_o
);
  logic asleep;

  always_comb begin
    asleep         = (state_i == LP_IDLE) || (state_i == LP_DOWN);
    cpu_clk_en_o   = (state_i == LP_RUN) || (state_i == LP_IDLE_RST);
    per_clk_en_o   = (state_i != LP_DOWN);
    ram_wr_block_o = (state_i == LP_IDLE_RST);
    idle_flag_o    = (state_i == LP_IDLE) || (state_i == LP_IDLE_RST);
    pd_flag_o      = (state_i == LP_DOWN);
    pin_hold_o     = asleep;
    pin_level_o    = (state_i == LP_IDLE);
    p0_float_o     = ext_code_i && asleep;
    p2_addr_hold_o = ext_code_i && (state_i == LP_IDLE);
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int MC_LEN = 12,
  parameter int RST_MC = 2,
  parameter int NIRQ   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rst_pin,
  input  logic            mode_wr,
  input  logic            idle_req,
  input  logic            pd_req,
  input  logic [NIRQ-1:0] irq,
  input  logic            ext_code,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            sys_rst,
  output logic            ram_wr_block,
  output logic            idle_flag,
  output logic            pd_flag,
  output logic            pin_hold,
  output logic            pin_level,
  output logic            p0_float,
  output logic            p2_addr_hold
);
  logic [1:0] rsync_q;
  logic       rst_ni;
  lp_state_t  state;
  logic       pin_s;
  logic       mc_tick;
  logic       osc_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  assign osc_on = (state != LP_DOWN) || pin_s;

  lpm_cycle_timer #(.MC_LEN(MC_LEN)) u_timer (
    .clk    (clk),
    .rst_ni (rst_ni),
    .run_i  (osc_on),
    .tick_o (mc_tick)
  );

  lpm_reset_filter #(.RST_MC(RST_MC)) u_filter (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .pin_i      (rst_pin),
    .tick_i     (mc_tick),
    .pin_sync_o (pin_s),
    .rst_o      (sys_rst)
  );

  lpm_mode_fsm #(.NIRQ(NIRQ)) u_fsm (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .sys_rst_i  (sys_rst),
    .pin_s_i    (pin_s),
    .tick_i     (mc_tick),
    .mode_wr_i  (mode_wr),
    .idle_req_i (idle_req),
    .pd_req_i   (pd_req),
    .irq_i      (irq),
    .state_o    (state)
  );

  lpm_pin_ctl u_pins (
    .state_i        (state),
    .ext_code_i     (ext_code),
    .cpu_clk_en_o   (cpu_clk_en),
    .per_clk_en_o   (per_clk_en),
    .ram_wr_block_o (ram_wr_block),
    .idle_flag_o    (idle_flag),
    .pd_flag_o      (pd_flag),
    .pin_hold_o     (pin_hold),
    .pin_level_o    (pin_level),
    .p0_float_o     (p0_float),
    .p2_addr_hold_o (p2_addr_hold)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic clk,
  input logic rst_ni,
  input logic mc_tick,
  input logic pin_s,
  input logic mode_wr,
  input logic idle_req,
  input logic pd_req,
  input logic ext_code,
  input logic cpu_clk_en,
  input logic sys_rst,
  input logic ram_wr_block,
  input logic idle_flag,
  input logic pd_flag,
  input logic pin_hold,
  input logic p0_float
);
  // R2
  idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(idle_flag) |-> $past(mode_wr && idle_req && !pd_req));

  // R3
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pd_flag) |-> $past(mode_wr && pd_req));

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ($fell(idle_flag) && !$past(sys_rst) && !$past(ram_wr_block)) |-> $past(mc_tick));

  // R5
  pd_exit_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (pd_flag && !sys_rst) |=> pd_flag);

  // R6
  rst_filter_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sys_rst |-> $past(pin_s));

  // R7
  rst_run_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sys_rst |=> (!idle_flag && !pd_flag && cpu_clk_en));

  // R8
  ram_block_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ram_wr_block |-> (cpu_clk_en && idle_flag));

  // R10
  p0_float_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    p0_float |-> (ext_code && pin_hold));
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .mc_tick      (mc_tick),
  .pin_s        (pin_s),
  .mode_wr      (mode_wr),
  .idle_req     (idle_req),
  .pd_req       (pd_req),
  .ext_code     (ext_code),
  .cpu_clk_en   (cpu_clk_en),
  .sys_rst      (sys_rst),
  .ram_wr_block (ram_wr_block),
  .idle_flag    (idle_flag),
  .pd_flag      (pd_flag),
  .pin_hold     (pin_hold),
  .p0_float     (p0_float)
);

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_ctrl_tb;
  localparam int MC   = 12;
  localparam int RMC  = 2;
  localparam int NIRQ = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_pin = 1'b0, mode_wr = 1'b0, idle_req = 1'b0, pd_req = 1'b0, ext_code = 1'b0;
  logic [NIRQ-1:0] irq = '0;
  logic cpu_clk_en, per_clk_en, sys_rst, ram_wr_block, idle_flag, pd_flag;
  logic pin_hold, pin_level, p0_float, p2_addr_hold;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  lpm_ctrl #(.MC_LEN(MC), .RST_MC(RMC), .NIRQ(NIRQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .mode_wr(mode_wr),
    .idle_req(idle_req), .pd_req(pd_req), .irq(irq), .ext_code(ext_code),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .sys_rst(sys_rst),
    .ram_wr_block(ram_wr_block), .idle_flag(idle_flag), .pd_flag(pd_flag),
    .pin_hold(pin_hold), .pin_level(pin_level), .p0_float(p0_float),
    .p2_addr_hold(p2_addr_hold)
  );

  // Behavioural model: mode 0 running, 1 light sleep, 2 deep sleep, 3 light sleep ended by pin
  int m_mode = 0, m_phase = 0, m_high = 0;
  bit m_pend = 0, m_p1 = 0, m_p2 = 0, m_r1 = 0, m_r2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_phase = 0; m_high = 0; m_pend = 0;
      m_p1 = 0; m_p2 = 0; m_r1 = 0; m_r2 = 0;
    end else begin
      if (!m_r2) begin
        m_mode = 0; m_phase = 0; m_high = 0; m_pend = 0; m_p1 = 0; m_p2 = 0;
      end else begin
        bit running, boundary, resetting;
        int nmode; bit npend;
        running   = (m_mode != 2) || m_p2;
        boundary  = running && (m_phase == MC - 1);
        resetting = (m_high == RMC);
        nmode = m_mode; npend = m_pend;
        if (resetting) begin nmode = 0; npend = 0; end
        else if (m_mode == 0) begin
          if (mode_wr && pd_req) nmode = 2;
          else if (mode_wr && idle_req) nmode = 1;
        end else if (m_mode == 1) begin
          if (m_p2) begin nmode = 3; npend = 0; end
          else if (boundary && (m_pend || (irq != 0))) begin nmode = 0; npend = 0; end
          else npend = m_pend || (irq != 0);
        end else if (m_mode == 3) begin
          if (!m_p2) nmode = 0;
        end
        if (!m_p2) m_high = 0;
        else if (boundary && m_high < RMC) m_high = m_high + 1;
        if (running) m_phase = boundary ? 0 : m_phase + 1;
        m_mode = nmode; m_pend = npend;
        m_p2 = m_p1; m_p1 = rst_pin;
      end
      m_r2 = m_r1; m_r1 = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic eq(input string req, input string what, input logic act, input logic exp);
    check(act === exp, req, what, int'(act), int'(exp));
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      eq("R4",  "cpu_clk_en",   cpu_clk_en,   (m_mode == 0) || (m_mode == 3));
      eq("R3",  "per_clk_en",   per_clk_en,   m_mode != 2);
      eq("R6",  "sys_rst",      sys_rst,      m_high == RMC);
      eq("R8",  "ram_wr_block", ram_wr_block, m_mode == 3);
      eq("R2",  "idle_flag",    idle_flag,    (m_mode == 1) || (m_mode == 3));
      eq("R5",  "pd_flag",      pd_flag,      m_mode == 2);
      eq("R9",  "pin_hold",     pin_hold,     (m_mode == 1) || (m_mode == 2));
      eq("R9",  "pin_level",    pin_level,    m_mode == 1);
      eq("R10", "p0_float",     p0_float,     ext_code && ((m_mode == 1) || (m_mode == 2)));
      eq("R10", "p2_addr_hold", p2_addr_hold, ext_code && (m_mode == 1));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_mode(input logic i_bit, input logic p_bit);
    mode_wr = 1'b1; idle_req = i_bit; pd_req = p_bit;
    step(1);
    mode_wr = 1'b0; idle_req = 1'b0; pd_req = 1'b0;
  endtask

  task automatic wait_for(input int limit, output bit seen, input int which);
    seen = 1'b0;
    for (int k = 0; k < limit && !seen; k++) begin
      step(1);
      case (which)
        0: seen = cpu_clk_en;
        1: seen = sys_rst;
        default: seen = !sys_rst;
      endcase
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    step(3);
    rst_n = 1'b1;
    step(3);
    cmp_en = 1'b1;
    // R1 reset state
    eq("R1", "cpu_clk_en", cpu_clk_en, 1'b1);
    eq("R1", "per_clk_en", per_clk_en, 1'b1);
    eq("R1", "sys_rst", sys_rst, 1'b0);
    eq("R1", "flags", idle_flag | pd_flag, 1'b0);
    eq("R1", "pin_hold", pin_hold, 1'b0);

    // R2 light sleep entry, external code
    ext_code = 1'b1;
    write_mode(1'b1, 1'b0);
    eq("R2", "idle_flag", idle_flag, 1'b1);
    eq("R2", "cpu_clk_en", cpu_clk_en, 1'b0);
    eq("R2", "per_clk_en", per_clk_en, 1'b1);
    eq("R9", "pin_level idle", pin_level, 1'b1);
    eq("R10", "p2_addr_hold idle", p2_addr_hold, 1'b1);
    step(3);
    // R4 one-cycle interrupt pulse is remembered
    irq = 5'b00100; step(1); irq = '0;
    wait_for(MC + 2, seen, 0);
    eq("R4", "woke by irq", seen, 1'b1);
    eq("R4", "idle_flag cleared", idle_flag, 1'b0);

    // R10 internal code: ports not released
    ext_code = 1'b0;
    step(5);
    write_mode(1'b1, 1'b0);
    eq("R10", "p0_float internal", p0_float, 1'b0);
    irq = 5'b10000;
    wait_for(MC + 2, seen, 0);
    irq = '0;
    eq("R4", "woke by held irq", seen, 1'b1);

    // R3 both bits select deep sleep
    ext_code = 1'b1;
    write_mode(1'b1, 1'b1);
    eq("R3", "pd_flag", pd_flag, 1'b1);
    eq("R3", "clocks off", cpu_clk_en | per_clk_en, 1'b0);
    eq("R9", "pin_level pd", pin_level, 1'b0);
    eq("R10", "p2_addr_hold pd", p2_addr_hold, 1'b0);
    eq("R10", "p0_float pd", p0_float, 1'b1);
    // R5 interrupts and writes ignored
    irq = '1; step(3 * MC); irq = '0;
    write_mode(1'b1, 1'b0);
    eq("R5", "pd held", pd_flag, 1'b1);
    eq("R5", "idle not set", idle_flag, 1'b0);

    // R6 pin restarts oscillator and resets
    rst_pin = 1'b1;
    wait_for(4 * MC, seen, 1);
    eq("R6", "sys_rst from pd", seen, 1'b1);
    step(2);
    rst_pin = 1'b0;
    wait_for(6, seen, 2);
    eq("R6", "sys_rst released", seen, 1'b1);
    eq("R7", "pd cleared", pd_flag, 1'b0);
    eq("R7", "cpu running", cpu_clk_en, 1'b1);

    // R6 short glitch does not reset
    step(4);
    rst_pin = 1'b1; step(MC / 2); rst_pin = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 3 * MC; k++) begin step(1); seen = seen | sys_rst; end
    eq("R6", "glitch filtered", seen, 1'b0);

    // R8 light sleep ended by reset pin
    write_mode(1'b1, 1'b0);
    rst_pin = 1'b1;
    step(3);
    eq("R8", "ram_wr_block", ram_wr_block, 1'b1);
    eq("R8", "cpu resumes", cpu_clk_en, 1'b1);
    wait_for(4 * MC, seen, 1);
    eq("R6", "sys_rst from idle", seen, 1'b1);
    // R2 writes ignored during sys_rst
    write_mode(1'b1, 1'b0);
    step(1);
    eq("R2", "write ignored in reset", idle_flag, 1'b0);
    rst_pin = 1'b0;
    wait_for(6, seen, 2);
    eq("R7", "idle cleared", idle_flag, 1'b0);

    // R8 pin falls before reset fires
    step(3);
    write_mode(1'b1, 1'b0);
    rst_pin = 1'b1; step(3); rst_pin = 1'b0; step(3);
    eq("R8", "block released", ram_wr_block, 1'b0);
    eq("R8", "back to run", idle_flag, 1'b0);
    step(2 * MC);

    done = 1'b1;
    cmp_en = 1'b0;
    summary();
    $finish;
  end
endmodule